// File: doc/BRIEF.md
# Even/Odd Block Deinterleaver

This block receives a frame of fixed-width blocks whose arrival order puts every even-numbered block first and every odd-numbered block after them. It puts them back into natural order. Each block is one wide word (32 bytes by default). Blocks enter through a valid/ready input port. An internal arrival counter selects a buffer slot for each block. The slot is the counter with its bits rotated by one place: the top bit moves to the bottom. This one fixed address transform undoes the even/odd split. No comparison or sorting logic is involved.

When the last block of a frame has been stored, the buffer is read at ascending slot addresses on a valid/ready output port. With one buffer bank, input is held off while the frame drains. With the two-bank option, the next frame fills the second bank while the first one drains. The frame length is a power of two, with 16 blocks as the default.

Top module: `deint_top`

## Requirements
- R1: After a synchronous reset, `in_ready` is 1 and `out_valid` is 0.
- R2: The block accepted at arrival position p (counting from 0 within the frame, with FRAME_LOG2 index bits) is emitted at output position {p[FRAME_LOG2-2:0], p[FRAME_LOG2-1]}. For 16 blocks, arrival position 1 goes to output 2, arrival position 8 goes to output 1, and positions 0 and 15 stay where they are.
- R3: A frame that arrives as blocks 0,2,4,...,N-2 followed by 1,3,...,N-1 is emitted as blocks 0,1,...,N-1 in that order. Payload bits are unchanged.
- R4: `out_valid` first rises in the cycle after the handshake that accepts the final block of a frame. It is never high while no complete frame is buffered.
- R5: With one bank, `in_ready` is low from the cycle after the final input handshake of a frame until the cycle after the final output handshake of that frame.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value into the next cycle.
- R7: With two banks, input is accepted while an earlier frame drains. `in_ready` is low only when both banks hold complete frames, and therefore only while `out_valid` is high.
- R8: A beat offered on `in_valid` while `in_ready` is low is not stored and does not advance the arrival position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input block offered |
| in_ready | output | 1 | Block can be accepted |
| in_data | input | BLOCK_W | Input block payload |
| out_valid | output | 1 | Output block available |
| out_ready | input | 1 | Downstream takes the output block |
| out_data | output | BLOCK_W | Output block payload, natural order |

## Verification
Both the one-bank and the two-bank variants are driven for eight frames each.

- **Counting payloads, full rate:** the first two frames carry their own block number in the low bits and run at full rate on both sides. A slot error shows up as a wrong number at a known output position.
- **Random payloads with random stalls:** random payloads with gaps on both sides show whether back-pressure and held outputs keep the order intact.
- **Alternating all-ones and all-zeros blocks, slow output:** this pattern exposes stuck or crossed data bits. Throttling the output to one beat in five makes the two-bank variant fill both banks.
- **Sparse input, open output:** this last pattern separates the timing of frame completion from the timing of readout.

// File: rtl/deint_pkg.sv
package deint_pkg;

    // Occupancy of one buffer bank
    typedef enum logic {
        SLOT_OPEN   = 1'b0,
        SLOT_LOADED = 1'b1
    } slot_state_e;

    // Moves the top bit of a w-bit value to the bottom, shifting the rest up by one
    function automatic int unsigned rotate_up(input int unsigned v, input int unsigned w);
        int unsigned m;
        m = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        return ((v << 1) | (v >> (w - 1))) & m;
    endfunction

endpackage

// File: rtl/deint_wr_ctrl.sv
module deint_wr_ctrl #(
    parameter int AW        = 4,
    parameter bit TWO_BANKS = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          bank_free,
    output logic          in_ready,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic          wr_bank,
    output logic          frame_done
);
    localparam logic [AW-1:0] LAST_POS = '1;

    logic [AW-1:0] pos_q;
    logic          bank_q;
    logic          take;

    assign in_ready   = bank_free;
    assign take       = in_valid && bank_free;
    assign wr_en      = take;
    assign wr_addr    = AW'(deint_pkg::rotate_up(32'(pos_q), AW));
    assign wr_bank    = bank_q;
    assign frame_done = take && (pos_q == LAST_POS);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (take) begin
            pos_q <= pos_q + 1'b1;
        end
    end

    generate
        if (TWO_BANKS) begin : g_toggle
            always_ff @(posedge clk) begin
                if (rst) begin
                    bank_q <= 1'b0;
                end else if (frame_done) begin
                    bank_q <= ~bank_q;
                end
            end
        end else begin : g_fixed
            assign bank_q = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/deint_rd_ctrl.sv
module deint_rd_ctrl #(
    parameter int AW        = 4,
    parameter bit TWO_BANKS = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          out_ready,
    input  logic          bank_full,
    output logic          out_valid,
    output logic [AW-1:0] rd_addr,
    output logic          rd_bank,
    output logic          frame_done
);
    localparam logic [AW-1:0] LAST_POS = '1;

    logic [AW-1:0] pos_q;
    logic          bank_q;
    logic          give;

    assign out_valid  = bank_full;
    assign give       = bank_full && out_ready;
    assign rd_addr    = pos_q;
    assign rd_bank    = bank_q;
    assign frame_done = give && (pos_q == LAST_POS);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (give) begin
            pos_q <= pos_q + 1'b1;
        end
    end

    generate
        if (TWO_BANKS) begin : g_toggle
            always_ff @(posedge clk) begin
                if (rst) begin
                    bank_q <= 1'b0;
                end else if (frame_done) begin
                    bank_q <= ~bank_q;
                end
            end
        end else begin : g_fixed
            assign bank_q = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/deint_store.sv
module deint_store #(
    parameter int W     = 256,
    parameter int AW    = 4,
    parameter int NBANK = 1
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic          wr_bank,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_bank,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] bank_rd [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && (NBANK == 1 || wr_bank == 1'(b))) begin
                mem[wr_addr] <= wr_data;
            end
        end

        assign bank_rd[b] = mem[rd_addr];
    end

    assign rd_data = (NBANK > 1 && rd_bank) ? bank_rd[NBANK-1] : bank_rd[0];
endmodule

// File: rtl/deint_top.sv
module deint_top #(
    parameter int FRAME_LOG2 = 4,
    parameter int BLOCK_W    = 256,
    parameter bit DOUBLE_BUF = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [BLOCK_W-1:0] in_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [BLOCK_W-1:0] out_data
);
    import deint_pkg::*;

    localparam int NBANK = DOUBLE_BUF ? 2 : 1;

    logic                  wr_en, wr_bank, wr_done;
    logic [FRAME_LOG2-1:0] wr_addr;
    logic                  rd_bank, rd_done;
    logic [FRAME_LOG2-1:0] rd_addr;
    logic                  bank_free, bank_full;
    slot_state_e           slot_q [NBANK];

    always_comb begin
        bank_free = (slot_q[0] == SLOT_OPEN);
        bank_full = (slot_q[0] == SLOT_LOADED);
        if (NBANK > 1 && wr_bank) bank_free = (slot_q[NBANK-1] == SLOT_OPEN);
        if (NBANK > 1 && rd_bank) bank_full = (slot_q[NBANK-1] == SLOT_LOADED);
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_slot
        logic hit_wr, hit_rd;
        assign hit_wr = wr_done && (NBANK == 1 || wr_bank == 1'(b));
        assign hit_rd = rd_done && (NBANK == 1 || rd_bank == 1'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[b] <= SLOT_OPEN;
            end else if (hit_wr) begin
                slot_q[b] <= SLOT_LOADED;
            end else if (hit_rd) begin
                slot_q[b] <= SLOT_OPEN;
            end
        end
    end

    deint_wr_ctrl #(.AW(FRAME_LOG2), .TWO_BANKS(DOUBLE_BUF)) wr_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .bank_free(bank_free),
        .in_ready(in_ready), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_bank(wr_bank), .frame_done(wr_done)
    );

    deint_rd_ctrl #(.AW(FRAME_LOG2), .TWO_BANKS(DOUBLE_BUF)) rd_i (
        .clk(clk), .rst(rst), .out_ready(out_ready), .bank_full(bank_full),
        .out_valid(out_valid), .rd_addr(rd_addr), .rd_bank(rd_bank),
        .frame_done(rd_done)
    );

    deint_store #(.W(BLOCK_W), .AW(FRAME_LOG2), .NBANK(NBANK)) store_i (
        .clk(clk), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
        .wr_data(in_data), .rd_bank(rd_bank), .rd_addr(rd_addr),
        .rd_data(out_data)
    );
endmodule

module deint_chk #(
    parameter int FRAME_LOG2 = 4,
    parameter int BLOCK_W    = 256,
    parameter bit DOUBLE_BUF = 1'b0
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_ready,
    input logic               out_valid,
    input logic               out_ready,
    input logic [BLOCK_W-1:0] out_data
);
    logic past_rst;
    always_ff @(posedge clk) past_rst <= rst;

    // R1
    reset_state_chk: assert property (@(posedge clk) past_rst |-> (in_ready && !out_valid));

    // R4
    frame_complete_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(in_valid && in_ready));

    // R6
    hold_output_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R7
    stall_reason_chk: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> out_valid);

    generate
        if (!DOUBLE_BUF) begin : g_single
            // R5
            single_bank_block_chk: assert property (@(posedge clk) disable iff (rst)
                out_valid |-> !in_ready);
        end
    endgenerate
endmodule

bind deint_top deint_chk #(
    .FRAME_LOG2(FRAME_LOG2), .BLOCK_W(BLOCK_W), .DOUBLE_BUF(DOUBLE_BUF)
) chk_i (.*);

// File: tb/deint_top_tb.sv
module deint_top_tb_top;
    localparam int LOG2 = 4;
    localparam int N    = 1 << LOG2;
    localparam int W    = 256;
    localparam int NFR  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    int errors = 0;
    int checks = 0;

    // Arrival position p carries block 2p in the first half, 2(p-N/2)+1 in the second
    function automatic int blk_of(input int p);
        return (p < N/2) ? 2*p : 2*(p - N/2) + 1;
    endfunction

    for (genvar g = 0; g < 2; g++) begin : gen_mode
        localparam bit DB = (g == 1);
        localparam int NB = DB ? 2 : 1;

        logic         in_valid = 1'b0;
        logic         in_ready;
        logic [W-1:0] in_data = '0;
        logic         out_valid;
        logic         out_ready = 1'b0;
        logic [W-1:0] out_data;

        deint_top #(.FRAME_LOG2(LOG2), .BLOCK_W(W), .DOUBLE_BUF(DB)) dut_i (
            .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
            .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
            .out_data(out_data)
        );

        bit           in_acc = 0, out_acc = 0, fin = 0;
        int           loaded = 0, wpos = 0, rpos = 0, out_frames = 0;
        logic [W-1:0] fbuf [N];
        logic [W-1:0] expq [$];
        logic         prev_ov = 1'b0, prev_or = 1'b0;
        logic [W-1:0] prev_od = '0;

        // R1 reset state, sampled while reset is still applied
        initial begin
            repeat (2) @(posedge clk);
            @(negedge clk);
            checks++;
            if (in_ready !== 1'b1 || out_valid !== 1'b0) begin
                errors++;
                $display("FAIL R1 mode=%0d in_ready=%0b out_valid=%0b expected 1 0",
                         g, in_ready, out_valid);
            end
        end

        // Reference model, compared every cycle
        always @(negedge clk) begin
            if (!rst) begin
                logic [W-1:0] exp_d;
                checks++;
                if (in_ready !== (loaded < NB)) begin
                    errors++;
                    $display("FAIL %s mode=%0d in_ready=%0b expected %0b",
                             DB ? "R7" : "R5", g, in_ready, (loaded < NB));
                end
                checks++;
                if (out_valid !== (loaded > 0)) begin
                    errors++;
                    $display("FAIL R4 mode=%0d out_valid=%0b expected %0b",
                             g, out_valid, (loaded > 0));
                end
                if (prev_ov && !prev_or) begin
                    checks++;
                    if (out_valid !== 1'b1 || out_data !== prev_od) begin
                        errors++;
                        $display("FAIL R6 mode=%0d out_valid=%0b data=%h expected 1 %h",
                                 g, out_valid, out_data, prev_od);
                    end
                end
                in_acc  = in_valid && in_ready;
                out_acc = out_valid && out_ready;
                if (out_acc) begin
                    checks++;
                    if (expq.size() == 0) begin
                        errors++;
                        $display("FAIL R4 mode=%0d output beat %h expected none", g, out_data);
                    end else begin
                        exp_d = expq.pop_front();
                        if (out_data !== exp_d) begin
                            errors++;
                            $display("FAIL R3 R8 mode=%0d slot=%0d data=%h expected %h",
                                     g, rpos, out_data, exp_d);
                        end
                    end
                    if (out_frames < 2) begin
                        checks++;
                        if (out_data[15:0] !== 16'(rpos)) begin
                            errors++;
                            $display("FAIL R2 mode=%0d slot=%0d block=%0d expected %0d",
                                     g, rpos, out_data[15:0], rpos);
                        end
                    end
                    rpos++;
                    if (rpos == N) begin
                        rpos = 0;
                        out_frames++;
                        loaded--;
                    end
                end
                if (in_acc) begin
                    fbuf[blk_of(wpos)] = in_data;
                    wpos++;
                    if (wpos == N) begin
                        for (int s = 0; s < N; s++) expq.push_back(fbuf[s]);
                        wpos = 0;
                        loaded++;
                    end
                end
                prev_ov = out_valid;
                prev_or = out_ready;
                prev_od = out_data;
            end
        end

        // Input driver: payload pattern and offer rate change per frame
        initial begin
            int sent;
            sent = 0;
            wait (!rst);
            while (sent < NFR*N) begin
                @(posedge clk);
                #1;
                if (in_acc) sent++;
                if (sent >= NFR*N) begin
                    in_valid = 1'b0;
                end else if (!in_valid || in_acc) begin
                    int fr, p, pv;
                    fr = sent / N;
                    p  = sent % N;
                    pv = (fr < 2) ? 100 : (fr < 4) ? 60 : (fr < 6) ? 100 : 30;
                    in_valid = (($urandom % 100) < pv);
                    if (fr < 2) begin
                        for (int k = 0; k < W/32; k++)
                            in_data[k*32 +: 32] = {16'(fr + k), 16'(blk_of(p))};
                    end else if (fr >= 4 && fr < 6) begin
                        in_data = (p % 2 == 1) ? '1 : '0;
                    end else begin
                        for (int k = 0; k < W/32; k++) in_data[k*32 +: 32] = $urandom;
                    end
                end
            end
            in_valid = 1'b0;
        end

        // Output driver: acceptance rate changes per drained frame
        initial begin
            wait (!rst);
            while (out_frames < NFR) begin
                int pr;
                @(posedge clk);
                #1;
                pr = (out_frames < 2) ? 100 : (out_frames < 4) ? 50 :
                     (out_frames < 6) ? 20 : 100;
                out_ready = (($urandom % 100) < pr);
            end
            out_ready = 1'b0;
            fin = 1'b1;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        fork
            wait (gen_mode[0].fin && gen_mode[1].fin);
            repeat (20000) @(posedge clk);
        join_any
        if (!(gen_mode[0].fin && gen_mode[1].fin)) begin
            checks++;
            errors++;
            $display("FAIL watchdog: frames drained %0d %0d expected %0d",
                     gen_mode[0].out_frames, gen_mode[1].out_frames, NFR);
        end
        repeat (2) @(posedge clk);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule